// File: doc/BRIEF.md
# FIFO fill-and-drain sequencer

This block exercises a synchronous FIFO by alternating between two phases. Once reset is released it stays quiet for a programmable number of cycles, so the FIFO has time to settle. It then pushes an incrementing 32-bit count into the FIFO on every cycle until the FIFO reports full. After a short idle gap of fixed length, it pops words on every cycle until the FIFO reports empty.

A checker inside the block compares each popped word against the expected count sequence. It also tallies pushes and pops in each phase. Two sticky flags report problems: one for data that arrives out of order, and one for phase counts that are wrong. The fill/drain pair repeats a set number of times, and then a done output rises. The FIFO itself is outside the block. It connects to the push, pop, full, empty and data pins. The FIFO must update full and empty at the clock edge, and it must present a popped word on its data output one cycle after the pop is accepted.

Top module: `fifo_exerciser`

## Requirements
- R1: While rst_n is low, wr_en_o, rd_en_o, done_o, data_err_o and count_err_o are all 0.
- R2: After rst_n rises, wr_en_o stays 0 for exactly HOLDOFF clock cycles. The cycle that starts at release is cycle 0, so the first write cycle is cycle HOLDOFF.
- R3: In a fill phase, wr_en_o is 1 in every cycle in which full_i is 0. din_o carries 0, 1, 2, … across all phases and advances by one after each cycle with wr_en_o high.
- R4: In any cycle in which full_i is 1, wr_en_o is 0. Once full ends a fill phase, no further write is issued until the next fill phase.
- R5: Between the last write of a fill phase and the first read of the drain, exactly GAP_CYCLES cycles have both wr_en_o and rd_en_o at 0. The cycle in which full is seen counts as one of them.
- R6: In the drain phase, rd_en_o is 1 in every cycle in which empty_i is 0. The first cycle with empty_i at 1 ends the phase, and in that cycle rd_en_o is 0.
- R7: On the cycle after each read, the block compares dout_i against the next value of the 0, 1, 2, … sequence. Any difference sets data_err_o, which stays 1 until reset.
- R8: count_err_o is set and held until reset in two cases. The first is when full ends a fill phase after a number of writes other than DEPTH. The second is when empty ends a drain phase after a number of reads different from that phase's number of writes.
- R9: After a drain phase ends, the block starts a new fill phase on the next cycle. After ITERATIONS drain phases, done_o rises and stays 1, and both enables stay 0.
- R10: wr_en_o and rd_en_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_o | output | 1 | Push strobe to the FIFO |
| din_o | output | DATA_W | Word to push |
| full_i | input | 1 | FIFO full flag |
| rd_en_o | output | 1 | Pop strobe to the FIFO |
| empty_i | input | 1 | FIFO empty flag |
| dout_i | input | DATA_W | Popped word, valid the cycle after a pop |
| data_err_o | output | 1 | Sticky: popped data out of sequence |
| count_err_o | output | 1 | Sticky: fill or drain count wrong |
| done_o | output | 1 | All iterations finished |

## Verification
A correct FIFO never makes either error flag rise. That makes the checker's two failure paths the hardest behaviour to reach from the ports. The bench therefore runs three copies of the sequencer side by side. The first drives a correct FIFO model, and the bench compares its enables, data and done output cycle by cycle against an arithmetic timeline. The second drives a FIFO model that is four entries too shallow, which must trip the count flag and leave the data flag clear. The third drives a FIFO model that flips one bit of one word in the second drain, which must trip only the data flag.

// File: rtl/fx_pkg.sv
package fx_pkg;

    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_WRITE = 3'd1,
        ST_GAP   = 3'd2,
        ST_READ  = 3'd3,
        ST_DONE  = 3'd4
    } fx_state_e;

endpackage

// File: rtl/fx_seq_fsm.sv
module fx_seq_fsm
    import fx_pkg::*;
#(
    parameter int HOLDOFF    = 8,
    parameter int GAP_CYCLES = 2,
    parameter int ITERATIONS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic full_i,
    input  logic empty_i,
    output logic wr_en_o,
    output logic rd_en_o,
    output logic done_o,
    output logic fill_end_o,
    output logic drain_end_o
);

    localparam int TMR_MAX  = (HOLDOFF > GAP_CYCLES) ? HOLDOFF : GAP_CYCLES;
    localparam int TMR_W    = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX + 1);
    localparam int IT_W     = (ITERATIONS < 2) ? 1 : $clog2(ITERATIONS);
    localparam int GAP_LAST = (GAP_CYCLES > 1) ? GAP_CYCLES - 2 : 0;

    typedef struct packed {
        fx_state_e        st;
        logic [TMR_W-1:0] tmr;
        logic [IT_W-1:0]  iter;
    } fsm_s;

    localparam fsm_s FSM_RST = '{st: ST_HOLD, tmr: '0, iter: '0};

    fsm_s fsm_d, fsm_q;
    logic fill_end, drain_end;

    always_comb begin
        fsm_d     = fsm_q;
        fill_end  = (fsm_q.st == ST_WRITE) && full_i;
        drain_end = (fsm_q.st == ST_READ) && empty_i;
        unique case (fsm_q.st)
            ST_HOLD: begin
                if (fsm_q.tmr == TMR_W'(HOLDOFF - 1)) begin
                    fsm_d.st  = ST_WRITE;
                    fsm_d.tmr = '0;
                end else begin
                    fsm_d.tmr = fsm_q.tmr + 1'b1;
                end
            end
            ST_WRITE: begin
                if (full_i) begin
                    fsm_d.st  = (GAP_CYCLES > 1) ? ST_GAP : ST_READ;
                    fsm_d.tmr = '0;
                end
            end
            ST_GAP: begin
                if (fsm_q.tmr == TMR_W'(GAP_LAST)) begin
                    fsm_d.st = ST_READ;
                end else begin
                    fsm_d.tmr = fsm_q.tmr + 1'b1;
                end
            end
            ST_READ: begin
                if (empty_i) begin
                    if (fsm_q.iter == IT_W'(ITERATIONS - 1)) begin
                        fsm_d.st = ST_DONE;
                    end else begin
                        fsm_d.st   = ST_WRITE;
                        fsm_d.iter = fsm_q.iter + 1'b1;
                    end
                end
            end
            default: fsm_d.st = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= FSM_RST;
        else        fsm_q <= fsm_d;
    end

    assign wr_en_o     = (fsm_q.st == ST_WRITE) && !full_i;
    assign rd_en_o     = (fsm_q.st == ST_READ) && !empty_i;
    assign done_o      = (fsm_q.st == ST_DONE);
    assign fill_end_o  = fill_end;
    assign drain_end_o = drain_end;

endmodule

// File: rtl/fx_pattern_gen.sv
module fx_pattern_gen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    output logic [DATA_W-1:0] din_o
);

    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en_i) word_d = word_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign din_o = word_q;

endmodule

// File: rtl/fx_read_check.sv
module fx_read_check #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              fill_end_i,
    input  logic              drain_end_i,
    input  logic [DATA_W-1:0] dout_i,
    output logic              data_err_o,
    output logic              count_err_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  wr_cnt;
        logic [CNT_W-1:0]  rd_cnt;
        logic [DATA_W-1:0] expect_word;
        logic              pend;
        logic              data_err;
        logic              count_err;
    } chk_s;

    chk_s chk_d, chk_q;

    always_comb begin
        chk_d      = chk_q;
        chk_d.pend = rd_en_i;
        if (wr_en_i) chk_d.wr_cnt = chk_q.wr_cnt + 1'b1;
        if (rd_en_i) chk_d.rd_cnt = chk_q.rd_cnt + 1'b1;
        if (chk_q.pend) begin
            chk_d.expect_word = chk_q.expect_word + 1'b1;
            if (dout_i != chk_q.expect_word) chk_d.data_err = 1'b1;
        end
        if (fill_end_i && (chk_q.wr_cnt != CNT_W'(DEPTH))) chk_d.count_err = 1'b1;
        if (drain_end_i) begin
            if (chk_q.rd_cnt != chk_q.wr_cnt) chk_d.count_err = 1'b1;
            chk_d.wr_cnt = '0;
            chk_d.rd_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign data_err_o  = chk_q.data_err;
    assign count_err_o = chk_q.count_err;

endmodule

// File: rtl/fifo_exerciser.sv
module fifo_exerciser #(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 8192,
    parameter int HOLDOFF    = 8,
    parameter int GAP_CYCLES = 2,
    parameter int ITERATIONS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] din_o,
    input  logic              full_i,
    output logic              rd_en_o,
    input  logic              empty_i,
    input  logic [DATA_W-1:0] dout_i,
    output logic              data_err_o,
    output logic              count_err_o,
    output logic              done_o
);

    logic fill_end, drain_end;

    fx_seq_fsm #(
        .HOLDOFF    (HOLDOFF),
        .GAP_CYCLES (GAP_CYCLES),
        .ITERATIONS (ITERATIONS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_i      (full_i),
        .empty_i     (empty_i),
        .wr_en_o     (wr_en_o),
        .rd_en_o     (rd_en_o),
        .done_o      (done_o),
        .fill_end_o  (fill_end),
        .drain_end_o (drain_end)
    );

    fx_pattern_gen #(.DATA_W(DATA_W)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_o),
        .din_o   (din_o)
    );

    fx_read_check #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_o),
        .rd_en_i     (rd_en_o),
        .fill_end_i  (fill_end),
        .drain_end_i (drain_end),
        .dout_i      (dout_i),
        .data_err_o  (data_err_o),
        .count_err_o (count_err_o)
    );

endmodule

// File: rtl/fx_sva.sv
module fx_sva #(
    parameter int DATA_W     = 32,
    parameter int HOLDOFF    = 8,
    parameter int GAP_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              empty,
    input logic              done,
    input logic [DATA_W-1:0] din
);

    localparam int AGE_W = (HOLDOFF < 2) ? 1 : $clog2(HOLDOFF + 1);

    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          age_q <= '0;
        else if (age_q != AGE_W'(HOLDOFF))   age_q <= age_q + 1'b1;
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) p_quiet_in_reset_r1: assert (!wr_en && !rd_en && !done);
    end

    p_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < AGE_W'(HOLDOFF)) |-> !wr_en);

    p_din_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (din == $past(din) + 1'b1));

    p_stop_after_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_en) |=> !wr_en);

    generate
        if (GAP_CYCLES == 2) begin : g_gap2
            p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(wr_en) |-> !rd_en ##1 !rd_en ##1 rd_en);
        end
    endgenerate

    p_rd_stops_on_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_en) && !done) |-> empty);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !wr_en && !rd_en));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

endmodule

bind fifo_exerciser fx_sva #(
    .DATA_W     (DATA_W),
    .HOLDOFF    (HOLDOFF),
    .GAP_CYCLES (GAP_CYCLES)
) u_sva (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en_o),
    .rd_en (rd_en_o),
    .empty (empty_i),
    .done  (done_o),
    .din   (din_o)
);

// File: tb/fifo_exerciser_tb.sv
module tb_fifo_model #(
    parameter int W       = 32,
    parameter int DEPTH   = 16,
    parameter int FLIP_AT = -1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    logic [W-1:0] mem [DEPTH];
    int wp, rp, cnt, nreads;

    assign full  = (cnt == DEPTH);
    assign empty = (cnt == 0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= 0; rp <= 0; cnt <= 0; nreads <= 0; dout <= '0;
        end else begin
            if (wr && !full) begin
                mem[wp] <= din;
                wp      <= (wp + 1) % DEPTH;
            end
            if (rd && !empty) begin
                dout   <= mem[rp] ^ ((nreads == FLIP_AT) ? W'(1) : W'(0));
                rp     <= (rp + 1) % DEPTH;
                nreads <= nreads + 1;
            end
            cnt <= cnt + ((wr && !full) ? 1 : 0) - ((rd && !empty) ? 1 : 0);
        end
    end
endmodule

module fifo_exerciser_tb;
    localparam int W     = 32;
    localparam int D     = 16;
    localparam int HO    = 5;
    localparam int GAP   = 2;
    localparam int ITER  = 3;
    localparam int P     = 2 * D + 3;
    localparam int LAST  = HO + ITER * P + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // three sequencers: correct FIFO, shallow FIFO, corrupting FIFO
    logic         a_wr, a_rd, a_full, a_empty, a_derr, a_cerr, a_done;
    logic [W-1:0] a_din, a_dout;
    logic         b_wr, b_rd, b_full, b_empty, b_derr, b_cerr, b_done;
    logic [W-1:0] b_din, b_dout;
    logic         c_wr, c_rd, c_full, c_empty, c_derr, c_cerr, c_done;
    logic [W-1:0] c_din, c_dout;

    fifo_exerciser #(.DATA_W(W), .DEPTH(D), .HOLDOFF(HO), .GAP_CYCLES(GAP), .ITERATIONS(ITER)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_o(a_wr), .din_o(a_din), .full_i(a_full),
        .rd_en_o(a_rd), .empty_i(a_empty), .dout_i(a_dout),
        .data_err_o(a_derr), .count_err_o(a_cerr), .done_o(a_done));
    tb_fifo_model #(.W(W), .DEPTH(D)) u_fa (
        .clk(clk), .rst_n(rst_n), .wr(a_wr), .din(a_din), .rd(a_rd),
        .dout(a_dout), .full(a_full), .empty(a_empty));

    fifo_exerciser #(.DATA_W(W), .DEPTH(D), .HOLDOFF(HO), .GAP_CYCLES(GAP), .ITERATIONS(ITER)) u_short (
        .clk(clk), .rst_n(rst_n), .wr_en_o(b_wr), .din_o(b_din), .full_i(b_full),
        .rd_en_o(b_rd), .empty_i(b_empty), .dout_i(b_dout),
        .data_err_o(b_derr), .count_err_o(b_cerr), .done_o(b_done));
    tb_fifo_model #(.W(W), .DEPTH(D - 4)) u_fb (
        .clk(clk), .rst_n(rst_n), .wr(b_wr), .din(b_din), .rd(b_rd),
        .dout(b_dout), .full(b_full), .empty(b_empty));

    fifo_exerciser #(.DATA_W(W), .DEPTH(D), .HOLDOFF(HO), .GAP_CYCLES(GAP), .ITERATIONS(ITER)) u_corrupt (
        .clk(clk), .rst_n(rst_n), .wr_en_o(c_wr), .din_o(c_din), .full_i(c_full),
        .rd_en_o(c_rd), .empty_i(c_empty), .dout_i(c_dout),
        .data_err_o(c_derr), .count_err_o(c_cerr), .done_o(c_done));
    tb_fifo_model #(.W(W), .DEPTH(D), .FLIP_AT(20)) u_fc (
        .clk(clk), .rst_n(rst_n), .wr(c_wr), .din(c_din), .rd(c_rd),
        .dout(c_dout), .full(c_full), .empty(c_empty));

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected region of cycle c after release:
    // 0 hold, 1 write, 2 idle after full/gap, 3 read, 4 empty cycle, 5 done
    function automatic int region(input int c);
        int k, o;
        if (c < HO) return 0;
        k = c - HO;
        if (k >= ITER * P) return 5;
        o = k % P;
        if (o < D) return 1;
        if (o < D + 2) return 2;
        if (o < 2 * D + 2) return 3;
        return 4;
    endfunction

    function automatic string tag_of(input int r);
        case (r)
            0: return "R2 holdoff";
            1: return "R3 fill";
            2: return "R5 gap";
            3: return "R6 drain";
            4: return "R6 empty stop";
            default: return "R9 done";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int r, k, o;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!a_wr && !a_rd, "R1 enables in reset", {a_wr, a_rd}, 0);
        check(!a_done && !a_derr && !a_cerr, "R1 flags in reset", {a_done, a_derr, a_cerr}, 0);
        check(!b_wr && !c_wr && !b_rd && !c_rd, "R1 other enables in reset", {b_wr, c_wr, b_rd, c_rd}, 0);
        rst_n = 1'b1;
        for (int c = 0; c <= LAST; c++) begin
            #1;
            r = region(c);
            k = c - HO;
            o = (k >= 0) ? k % P : 0;
            check(a_wr == (r == 1), tag_of(r), a_wr, (r == 1));
            check(a_rd == (r == 3), tag_of(r), a_rd, (r == 3));
            check(a_done == (r == 5), "R9 done timing", a_done, (r == 5));
            check(!(a_wr && a_rd), "R10 exclusive", {a_wr, a_rd}, 0);
            if (a_full) check(!a_wr, "R4 no write while full", a_wr, 0);
            if (r == 1)
                check(a_din == W'((k / P) * D + o), "R3 din sequence", a_din, W'((k / P) * D + o));
            if (c == 0) check(!a_wr && !a_rd, "R1 at release", {a_wr, a_rd}, 0);
            if (c == HO + 50) check(!c_derr, "R7 no flag before bad word", c_derr, 0);
            check(!a_derr && !a_cerr, "R7 R8 clean run flags", {a_derr, a_cerr}, 0);
            @(negedge clk);
        end
        #1;
        check(b_done && c_done, "R9 faulty runs finish", {b_done, c_done}, 2'b11);
        check(b_cerr == 1'b1, "R8 shallow fifo count flag", b_cerr, 1);
        check(b_derr == 1'b0, "R7 shallow fifo data clean", b_derr, 0);
        check(c_derr == 1'b1, "R7 corrupted word flag", c_derr, 1);
        check(c_cerr == 1'b0, "R8 corrupt fifo counts clean", c_cerr, 0);
        check(!a_wr && !a_rd && a_done, "R9 stays done", {a_wr, a_rd, a_done}, 1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule